// File: doc/BRIEF.md
# Double-Buffered Endpoint Packet Buffer

This block holds the packet data of one bulk or interrupt endpoint of a peripheral-side serial bus controller. It owns two packet slots that alternate in ping-pong order. In the IN direction, the processor writes bytes over a 16-bit bus. A packet is handed to the host side once it is complete: either it has reached the configured maximum packet size, or it has reached a one-shot short length written into the count register, or firmware has closed it by hand. The host side then reads the packet out byte by byte. In the OUT direction the roles swap. The host side writes bytes and acknowledges each packet. The count register is then reloaded with the number of bytes delivered, and the processor reads the packet back two bytes at a time. An odd final byte always arrives in the low byte lane.

A two-bit fill indication tells both sides how many slots hold data. A sticky flag records any write or packet close that was attempted while both slots were occupied. The direction and the maximum packet size are static configuration inputs, changed only under reset or bus reset. Bus reset clears the block just as the asynchronous reset does.

Top module: `ep_pkt_buffer`

## Requirements
- R1: After `rst_n` low, or after a cycle with `bus_rst` high, `buf_status` is 00, `ovf_err` is 0, `cpu_len_rdata` is 0 and `host_pkt_rdy` is 0.
- R2: With `cfg_dir_in`=1 and no short length pending, a packet is closed automatically in the cycle its byte count reaches `cfg_mps`, and it is offered with `host_pkt_len` equal to `cfg_mps`. No earlier byte count closes it.
- R3: With `cfg_dir_in`=1, writing a value L with 0 < L < `cfg_mps` to the count register (`cpu_len_wr`) closes the next packet automatically when it holds L bytes.
- R4: With `cfg_dir_in`=1, every packet close loads the count register with `cfg_mps`, so a short length applies to one packet only.
- R5: With `cfg_dir_in`=1, a `cpu_vend` pulse closes the packet being filled with the number of bytes written so far. Zero is a legal count, and a zero-length packet is released by one host read.
- R6: Each processor write stores `cpu_wdata[7:0]` as the earlier byte and `cpu_wdata[15:8]` as the next byte only when `cpu_wr_hi` is 1. Bytes that would pass the packet's target length are dropped.
- R7: With `cfg_dir_in`=0, a `host_ack` pulse closes the packet that the host wrote and loads the count register with its byte count.
- R8: With `cfg_dir_in`=0, each `cpu_rd` returns the earlier byte on `cpu_rdata[7:0]` and the next byte on `cpu_rdata[15:8]` with `cpu_rd_hi_vld`=1. An odd final byte comes back on the low lane, with the high lane 0 and `cpu_rd_hi_vld`=0.
- R9: `buf_status` is 00 when no slot holds a closed packet, 01 when exactly one does, and 11 when both do.
- R10: While both slots are occupied, writes and packet-close requests change nothing, and `ovf_err` is set. It stays set until reset or bus reset.
- R11: Packets are drained oldest first. A slot is freed in the cycle its last byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Synchronous bus reset, clears the whole block |
| cfg_dir_in | input | 1 | 1: IN endpoint (processor fills), 0: OUT endpoint (host fills) |
| cfg_mps | input | 10 | Maximum packet size in bytes, 8 to 512 |
| cpu_wr | input | 1 | Processor write strobe (IN) |
| cpu_wdata | input | 16 | Processor write data, low lane first |
| cpu_wr_hi | input | 1 | Upper byte lane of the write is valid |
| cpu_vend | input | 1 | Close the current IN packet by hand |
| cpu_len_wr | input | 1 | Write the count register |
| cpu_len_wdata | input | 16 | Count register write value |
| cpu_len_rdata | output | 16 | Count register contents |
| cpu_rd | input | 1 | Processor read strobe (OUT) |
| cpu_rdata | output | 16 | Processor read data, valid the cycle after `cpu_rd` |
| cpu_rd_hi_vld | output | 1 | Upper lane of `cpu_rdata` holds a packet byte |
| host_wr | input | 1 | Host byte write strobe (OUT) |
| host_wbyte | input | 8 | Host write byte |
| host_ack | input | 1 | Host packet acknowledged, closes the OUT packet |
| host_rd | input | 1 | Host byte read strobe (IN) |
| host_rdata | output | 8 | Host read byte, valid the cycle after `host_rd` |
| host_pkt_rdy | output | 1 | An IN packet is ready for the host |
| host_pkt_len | output | 10 | Length of the oldest closed packet |
| buf_status | output | 2 | Slot occupancy code |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
Every result is registered at the clock edge that samples its stimulus, so the slot status, the count register, the offered length and the overflow flag change one cycle after the write, close or read that caused them. Read data lands in the same cycle. The bench drives each strobe for exactly one cycle, starting at a falling edge, and samples at the next falling edge. Each result is therefore checked in the first cycle it is due, and before the next stimulus can disturb it. Slot order, lane placement and dropped writes are judged only through the read data and status seen at the ports.

// File: rtl/epb_pkg.sv
package epb_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'b00,
    ST_ONE   = 2'b01,
    ST_BOTH  = 2'b11
  } slot_state_e;

  function automatic slot_state_e encode_slots(input logic [1:0] occ);
    slot_state_e st;
    if (occ[0] && occ[1])      st = ST_BOTH;
    else if (occ[0] || occ[1]) st = ST_ONE;
    else                       st = ST_EMPTY;
    return st;
  endfunction

endpackage

// File: rtl/epb_mem.sv
module epb_mem #(
  parameter int BUF_BYTES = 512,
  parameter int AW        = 9
) (
  input  logic          clk,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic          wsel,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wd_lo,
  input  logic [7:0]    wd_hi,
  input  logic          rsel,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rd_lo,
  output logic [7:0]    rd_hi
);

  localparam int DEPTH = 2 * BUF_BYTES;

  logic [7:0]    store [DEPTH];
  logic [AW-1:0] waddr_hi;
  logic [AW-1:0] raddr_hi;

  always_comb begin
    waddr_hi = waddr + AW'(1);
    raddr_hi = raddr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (we_lo) store[{wsel, waddr}]    <= wd_lo;
    if (we_hi) store[{wsel, waddr_hi}] <= wd_hi;
  end

  always_comb begin
    rd_lo = store[{rsel, raddr}];
    rd_hi = store[{rsel, raddr_hi}];
  end

endmodule

// File: rtl/epb_fill.sv
module epb_fill #(
  parameter int BUF_BYTES = 512,
  parameter int LW        = 10,
  parameter int AW        = 9,
  parameter int DCW       = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           dir_in,
  input  logic [LW-1:0]  mps,
  input  logic           wr_req,
  input  logic           wr_two,
  input  logic           close_req,
  input  logic           len_wr,
  input  logic [DCW-1:0] len_wdata,
  input  logic           slot_busy,
  output logic           mem_we_lo,
  output logic           mem_we_hi,
  output logic [AW-1:0]  mem_addr,
  output logic           close_pkt,
  output logic [LW-1:0]  close_len,
  output logic           ovf_hit,
  output logic [DCW-1:0] dcount
);

  logic [LW-1:0]  fill_cnt, fill_nxt;
  logic [DCW-1:0] dcount_nxt;
  logic           short_on;
  logic [LW-1:0]  target;
  logic [LW-1:0]  room;
  logic           wr_ok, two_ok, auto_hit;
  logic [LW-1:0]  nbytes, cnt_sum;
  logic           fill_en, dcount_en;

  // target length: one-shot short value if pending, else max packet size
  always_comb begin
    short_on = dir_in && (dcount != '0) && (dcount < DCW'(mps));
    target   = short_on ? LW'(dcount) : mps;
    room     = (fill_cnt < target) ? (target - fill_cnt) : '0;
    wr_ok    = wr_req && !slot_busy && (room != '0);
    two_ok   = wr_ok && wr_two && (room >= LW'(2));
    nbytes   = two_ok ? LW'(2) : (wr_ok ? LW'(1) : '0);
    cnt_sum  = fill_cnt + nbytes;
    auto_hit = dir_in && wr_ok && (cnt_sum == target);
    close_pkt = !slot_busy && (close_req || auto_hit);
    close_len = cnt_sum;
    ovf_hit   = slot_busy && (wr_req || close_req);
    mem_we_lo = wr_ok;
    mem_we_hi = two_ok;
    mem_addr  = fill_cnt[AW-1:0];
  end

  always_comb begin
    fill_en    = wr_ok || close_pkt;
    fill_nxt   = close_pkt ? '0 : cnt_sum;
    dcount_en  = len_wr || close_pkt;
    if (len_wr)      dcount_nxt = len_wdata;
    else if (dir_in) dcount_nxt = DCW'(mps);
    else             dcount_nxt = DCW'(cnt_sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      dcount   <= '0;
    end else if (clr) begin
      fill_cnt <= '0;
      dcount   <= '0;
    end else begin
      if (fill_en)   fill_cnt <= fill_nxt;
      if (dcount_en) dcount   <= dcount_nxt;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n || clr)
    fill_cnt <= LW'(BUF_BYTES)); // R6

  AST_SHORT_REVERT: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (dir_in && close_pkt && !len_wr) |=> (dcount == DCW'($past(mps)))); // R4

  AST_BUSY_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (slot_busy && (wr_req || close_req)) |=> $stable(fill_cnt)); // R10

endmodule

// File: rtl/epb_ring.sv
module epb_ring #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          close_pkt,
  input  logic [LW-1:0] close_len,
  input  logic          release_slot,
  input  logic          ovf_hit,
  output logic          wr_sel,
  output logic          rd_sel,
  output logic          wr_busy,
  output logic          rd_full,
  output logic [LW-1:0] rd_len,
  output logic [1:0]    status,
  output logic          ovf_err
);

  import epb_pkg::*;

  logic [1:0]    occ;
  logic [LW-1:0] slot_len [2];
  logic          wr_sel_nxt, rd_sel_nxt, ovf_nxt;

  for (genvar b = 0; b < 2; b++) begin : g_slot
    logic          full_r, full_nxt;
    logic [LW-1:0] len_r;
    logic          set_b, free_b;

    always_comb begin
      set_b  = close_pkt && (wr_sel == 1'(b));
      free_b = release_slot && (rd_sel == 1'(b));
      if (set_b)       full_nxt = 1'b1;
      else if (free_b) full_nxt = 1'b0;
      else             full_nxt = full_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_r <= 1'b0;
        len_r  <= '0;
      end else if (clr) begin
        full_r <= 1'b0;
        len_r  <= '0;
      end else begin
        if (set_b || free_b) full_r <= full_nxt;
        if (set_b)           len_r  <= close_len;
      end
    end

    assign occ[b]      = full_r;
    assign slot_len[b] = len_r;
  end

  always_comb begin
    wr_sel_nxt = wr_sel ^ close_pkt;
    rd_sel_nxt = rd_sel ^ release_slot;
    ovf_nxt    = ovf_err | ovf_hit;
    wr_busy    = occ[wr_sel];
    rd_full    = occ[rd_sel];
    rd_len     = slot_len[rd_sel];
    status     = encode_slots(occ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sel  <= 1'b0;
      rd_sel  <= 1'b0;
      ovf_err <= 1'b0;
    end else if (clr) begin
      wr_sel  <= 1'b0;
      rd_sel  <= 1'b0;
      ovf_err <= 1'b0;
    end else begin
      if (close_pkt)    wr_sel  <= wr_sel_nxt;
      if (release_slot) rd_sel  <= rd_sel_nxt;
      if (ovf_hit)      ovf_err <= ovf_nxt;
    end
  end

  AST_CLOSE_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n || clr)
    close_pkt |-> !occ[wr_sel]); // R10

  AST_RELEASE_FULL: assert property (@(posedge clk) disable iff (!rst_n || clr)
    release_slot |-> occ[rd_sel]); // R11

  AST_OLDEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ($countones(occ) == 1) |-> (occ[rd_sel] && !occ[wr_sel])); // R11

  AST_BOTH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (occ == 2'b11) |-> (wr_sel == rd_sel)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ovf_err |=> ovf_err); // R10

endmodule

// File: rtl/epb_drain.sv
module epb_drain #(
  parameter int LW = 10,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rd_req,
  input  logic          two_lane,
  input  logic          rd_full,
  input  logic [LW-1:0] rd_len,
  input  logic [7:0]    mem_lo,
  input  logic [7:0]    mem_hi,
  output logic [AW-1:0] mem_raddr,
  output logic          release_slot,
  output logic [7:0]    rd_lo,
  output logic [7:0]    rd_hi,
  output logic          rd_hi_vld
);

  logic [LW-1:0] rd_ptr, ptr_nxt;
  logic [LW-1:0] rem, step;
  logic          go, take_lo, take_hi;
  logic [7:0]    lo_nxt, hi_nxt;

  always_comb begin
    rem          = (rd_len > rd_ptr) ? (rd_len - rd_ptr) : '0;
    go           = rd_req && rd_full;
    take_hi      = go && two_lane && (rem >= LW'(2));
    take_lo      = go && (rem != '0);
    step         = take_hi ? LW'(2) : (take_lo ? LW'(1) : '0);
    release_slot = go && ((rd_ptr + step) >= rd_len);
    ptr_nxt      = release_slot ? '0 : (rd_ptr + step);
    lo_nxt       = take_lo ? mem_lo : 8'h00;
    hi_nxt       = take_hi ? mem_hi : 8'h00;
    mem_raddr    = rd_ptr[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      rd_lo     <= '0;
      rd_hi     <= '0;
      rd_hi_vld <= 1'b0;
    end else if (clr) begin
      rd_ptr    <= '0;
      rd_lo     <= '0;
      rd_hi     <= '0;
      rd_hi_vld <= 1'b0;
    end else if (go) begin
      rd_ptr    <= ptr_nxt;
      rd_lo     <= lo_nxt;
      rd_hi     <= hi_nxt;
      rd_hi_vld <= take_hi;
    end
  end

  AST_PTR_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n || clr)
    rd_full |-> (rd_ptr <= rd_len)); // R11

  AST_ODD_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (go && two_lane && (rem == LW'(1))) |=> (!rd_hi_vld && (rd_hi == 8'h00))); // R8

endmodule

// File: rtl/ep_pkt_buffer.sv
module ep_pkt_buffer #(
  parameter int BUF_BYTES = 512,
  parameter int DCW       = 16,
  parameter int LW        = $clog2(BUF_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_rst,
  input  logic           cfg_dir_in,
  input  logic [LW-1:0]  cfg_mps,
  input  logic           cpu_wr,
  input  logic [15:0]    cpu_wdata,
  input  logic           cpu_wr_hi,
  input  logic           cpu_vend,
  input  logic           cpu_len_wr,
  input  logic [DCW-1:0] cpu_len_wdata,
  output logic [DCW-1:0] cpu_len_rdata,
  input  logic           cpu_rd,
  output logic [15:0]    cpu_rdata,
  output logic           cpu_rd_hi_vld,
  input  logic           host_wr,
  input  logic [7:0]     host_wbyte,
  input  logic           host_ack,
  input  logic           host_rd,
  output logic [7:0]     host_rdata,
  output logic           host_pkt_rdy,
  output logic [LW-1:0]  host_pkt_len,
  output logic [1:0]     buf_status,
  output logic           ovf_err
);

  localparam int AW = $clog2(BUF_BYTES);

  logic          prod_wr, prod_two, prod_close;
  logic [7:0]    prod_lo, prod_hi;
  logic          cons_rd, cons_two;
  logic          we_lo, we_hi;
  logic [AW-1:0] waddr, raddr;
  logic          close_pkt, ovf_hit, release_slot;
  logic [LW-1:0] close_len, rd_len;
  logic          wr_sel, rd_sel, wr_busy, rd_full;
  logic [7:0]    mem_lo, mem_hi, rd_lo, rd_hi;
  logic          rd_hi_vld;

  // direction picks which side produces and which side consumes
  always_comb begin
    prod_wr    = cfg_dir_in ? cpu_wr : host_wr;
    prod_two   = cfg_dir_in && cpu_wr_hi;
    prod_close = cfg_dir_in ? cpu_vend : host_ack;
    prod_lo    = cfg_dir_in ? cpu_wdata[7:0] : host_wbyte;
    prod_hi    = cpu_wdata[15:8];
    cons_rd    = cfg_dir_in ? host_rd : cpu_rd;
    cons_two   = !cfg_dir_in;
  end

  epb_fill #(.BUF_BYTES(BUF_BYTES), .LW(LW), .AW(AW), .DCW(DCW)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr(bus_rst), .dir_in(cfg_dir_in), .mps(cfg_mps),
    .wr_req(prod_wr), .wr_two(prod_two), .close_req(prod_close),
    .len_wr(cpu_len_wr), .len_wdata(cpu_len_wdata), .slot_busy(wr_busy),
    .mem_we_lo(we_lo), .mem_we_hi(we_hi), .mem_addr(waddr),
    .close_pkt(close_pkt), .close_len(close_len), .ovf_hit(ovf_hit),
    .dcount(cpu_len_rdata)
  );

  epb_ring #(.LW(LW)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(bus_rst),
    .close_pkt(close_pkt), .close_len(close_len), .release_slot(release_slot),
    .ovf_hit(ovf_hit), .wr_sel(wr_sel), .rd_sel(rd_sel), .wr_busy(wr_busy),
    .rd_full(rd_full), .rd_len(rd_len), .status(buf_status), .ovf_err(ovf_err)
  );

  epb_mem #(.BUF_BYTES(BUF_BYTES), .AW(AW)) u_mem (
    .clk(clk), .we_lo(we_lo), .we_hi(we_hi), .wsel(wr_sel), .waddr(waddr),
    .wd_lo(prod_lo), .wd_hi(prod_hi), .rsel(rd_sel), .raddr(raddr),
    .rd_lo(mem_lo), .rd_hi(mem_hi)
  );

  epb_drain #(.LW(LW), .AW(AW)) u_drain (
    .clk(clk), .rst_n(rst_n), .clr(bus_rst), .rd_req(cons_rd), .two_lane(cons_two),
    .rd_full(rd_full), .rd_len(rd_len), .mem_lo(mem_lo), .mem_hi(mem_hi),
    .mem_raddr(raddr), .release_slot(release_slot),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_hi_vld(rd_hi_vld)
  );

  always_comb begin
    cpu_rdata     = {rd_hi, rd_lo};
    cpu_rd_hi_vld = rd_hi_vld;
    host_rdata    = rd_lo;
    host_pkt_rdy  = cfg_dir_in && rd_full;
    host_pkt_len  = rd_len;
  end

endmodule

// File: tb/test_ep_pkt_buffer.sv
module test_ep_pkt_buffer;

  logic        clk = 1'b0;
  logic        rst_n, bus_rst, cfg_dir_in;
  logic [9:0]  cfg_mps;
  logic        cpu_wr, cpu_wr_hi, cpu_vend, cpu_len_wr, cpu_rd;
  logic [15:0] cpu_wdata, cpu_len_wdata, cpu_len_rdata, cpu_rdata;
  logic        cpu_rd_hi_vld;
  logic        host_wr, host_ack, host_rd, host_pkt_rdy;
  logic [7:0]  host_wbyte, host_rdata;
  logic [9:0]  host_pkt_len;
  logic [1:0]  buf_status;
  logic        ovf_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ep_pkt_buffer i_ep_pkt_buffer (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .cfg_dir_in(cfg_dir_in), .cfg_mps(cfg_mps),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_wr_hi(cpu_wr_hi), .cpu_vend(cpu_vend),
    .cpu_len_wr(cpu_len_wr), .cpu_len_wdata(cpu_len_wdata), .cpu_len_rdata(cpu_len_rdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_rd_hi_vld(cpu_rd_hi_vld),
    .host_wr(host_wr), .host_wbyte(host_wbyte), .host_ack(host_ack), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_pkt_rdy(host_pkt_rdy), .host_pkt_len(host_pkt_len),
    .buf_status(buf_status), .ovf_err(ovf_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_word(input logic [7:0] lo, input logic [7:0] hi, input bit two);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = {hi, lo}; cpu_wr_hi = two;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_wr_hi = 1'b0;
  endtask

  task automatic cpu_close();
    @(negedge clk); cpu_vend = 1'b1;
    @(negedge clk); cpu_vend = 1'b0;
  endtask

  task automatic cpu_set_len(input logic [15:0] v);
    @(negedge clk); cpu_len_wr = 1'b1; cpu_len_wdata = v;
    @(negedge clk); cpu_len_wr = 1'b0;
  endtask

  task automatic host_get(output logic [7:0] b);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; b = host_rdata;
  endtask

  task automatic cpu_get(output logic [15:0] d, output logic hv);
    @(negedge clk); cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata; hv = cpu_rd_hi_vld;
  endtask

  task automatic host_put(input logic [7:0] b);
    @(negedge clk); host_wr = 1'b1; host_wbyte = b;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic host_close();
    @(negedge clk); host_ack = 1'b1;
    @(negedge clk); host_ack = 1'b0;
  endtask

  task automatic pulse_bus_reset();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  // drain n bytes on the host side, expecting seed+k
  task automatic host_drain(input int n, input logic [7:0] seed, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      host_get(b);
      chk(req, "host byte", b, 8'(seed + k));
    end
  endtask

  task automatic t_reset();
    chk("R1", "status after reset", buf_status, 2'b00);
    chk("R1", "ovf after reset", ovf_err, 1'b0);
    chk("R1", "count after reset", cpu_len_rdata, 16'd0);
    chk("R1", "pkt_rdy after reset", host_pkt_rdy, 1'b0);
  endtask

  task automatic t_in_full_packet();
    for (int i = 0; i < 32; i++) begin
      cpu_word(8'(8'h10 + 2*i), 8'(8'h11 + 2*i), 1'b1);
      if (i == 30) chk("R2", "not closed at 62 bytes", buf_status, 2'b00);
    end
    chk("R2", "closed at mps", buf_status, 2'b01);
    chk("R9", "one slot code", buf_status, 2'b01);
    chk("R2", "offered length", host_pkt_len, 10'd64);
    chk("R2", "pkt_rdy", host_pkt_rdy, 1'b1);
    chk("R4", "count reads mps", cpu_len_rdata, 16'd64);
    host_drain(64, 8'h10, "R2");
    chk("R11", "freed after last byte", buf_status, 2'b00);
  endtask

  task automatic t_in_short_and_full();
    cpu_set_len(16'd62);
    for (int i = 0; i < 31; i++) begin
      cpu_word(8'(8'h20 + 2*i), 8'(8'h21 + 2*i), 1'b1);
      if (i == 29) chk("R3", "not closed at 60", buf_status, 2'b00);
    end
    chk("R3", "short packet closed", buf_status, 2'b01);
    chk("R3", "short length offered", host_pkt_len, 10'd62);
    chk("R4", "count reverted", cpu_len_rdata, 16'd64);
    for (int i = 0; i < 32; i++) begin
      cpu_word(8'(8'h80 + 2*i), 8'(8'h81 + 2*i), 1'b1);
      if (i == 30) chk("R4", "second not closed at 62", buf_status, 2'b01);
    end
    chk("R9", "both slots code", buf_status, 2'b11);
    chk("R10", "no ovf yet", ovf_err, 1'b0);
    cpu_word(8'hAA, 8'hBB, 1'b1);
    chk("R10", "ovf set on write", ovf_err, 1'b1);
    chk("R10", "status kept", buf_status, 2'b11);
    cpu_close();
    chk("R10", "close ignored", buf_status, 2'b11);
    chk("R11", "oldest offered first", host_pkt_len, 10'd62);
    host_drain(62, 8'h20, "R11");
    chk("R11", "one left", buf_status, 2'b01);
    chk("R11", "second length", host_pkt_len, 10'd64);
    host_drain(64, 8'h80, "R10");
    chk("R11", "all freed", buf_status, 2'b00);
    chk("R10", "ovf sticky", ovf_err, 1'b1);
  endtask

  task automatic t_in_force();
    logic [7:0] b;
    for (int i = 0; i < 5; i++) cpu_word(8'(8'h40 + 2*i), 8'(8'h41 + 2*i), 1'b1);
    cpu_word(8'h4A, 8'hEE, 1'b0);
    chk("R5", "not yet closed", buf_status, 2'b00);
    cpu_close();
    chk("R5", "forced close", buf_status, 2'b01);
    chk("R5", "forced length", host_pkt_len, 10'd11);
    host_drain(11, 8'h40, "R6");
    chk("R6", "single-lane write freed at 11", buf_status, 2'b00);
    cpu_close();
    chk("R5", "zero-length closed", buf_status, 2'b01);
    chk("R5", "zero length", host_pkt_len, 10'd0);
    host_get(b);
    chk("R5", "zero-length released", buf_status, 2'b00);
  endtask

  task automatic t_in_clip();
    cpu_set_len(16'd3);
    cpu_word(8'h61, 8'h62, 1'b1);
    cpu_word(8'h63, 8'hEE, 1'b1);
    chk("R6", "clipped close", buf_status, 2'b01);
    chk("R6", "clipped length", host_pkt_len, 10'd3);
    host_drain(3, 8'h61, "R6");
    chk("R6", "freed", buf_status, 2'b00);
    chk("R4", "count reverted after clip", cpu_len_rdata, 16'd64);
  endtask

  task automatic t_out();
    logic [15:0] d;
    logic        hv;
    cfg_dir_in = 1'b0;
    pulse_bus_reset();
    chk("R1", "bus reset ovf", ovf_err, 1'b0);
    chk("R1", "bus reset count", cpu_len_rdata, 16'd0);
    chk("R1", "bus reset status", buf_status, 2'b00);
    for (int i = 0; i < 5; i++) host_put(8'(8'h21 + i));
    chk("R7", "open until ack", buf_status, 2'b00);
    host_close();
    chk("R7", "count loaded 5", cpu_len_rdata, 16'd5);
    chk("R7", "slot closed", buf_status, 2'b01);
    chk("R7", "no host pkt_rdy in OUT", host_pkt_rdy, 1'b0);
    for (int i = 0; i < 7; i++) host_put(8'(8'h31 + i));
    host_close();
    chk("R7", "count loaded 7", cpu_len_rdata, 16'd7);
    chk("R9", "both slots OUT", buf_status, 2'b11);
    cpu_get(d, hv);
    chk("R8", "word0", {hv, d}, {1'b1, 16'h2221});
    cpu_get(d, hv);
    chk("R8", "word1", {hv, d}, {1'b1, 16'h2423});
    chk("R11", "not freed early", buf_status, 2'b11);
    cpu_get(d, hv);
    chk("R8", "odd tail low lane", {hv, d}, {1'b0, 16'h0025});
    chk("R11", "first slot freed", buf_status, 2'b01);
    for (int i = 0; i < 3; i++) begin
      cpu_get(d, hv);
      chk("R11", "second packet word", {hv, d},
          {1'b1, 8'(8'h32 + 2*i), 8'(8'h31 + 2*i)});
    end
    cpu_get(d, hv);
    chk("R8", "second odd tail", {hv, d}, {1'b0, 16'h0037});
    chk("R11", "all OUT freed", buf_status, 2'b00);
  endtask

  initial begin
    rst_n = 1'b0; bus_rst = 1'b0; cfg_dir_in = 1'b1; cfg_mps = 10'd64;
    cpu_wr = 1'b0; cpu_wdata = '0; cpu_wr_hi = 1'b0; cpu_vend = 1'b0;
    cpu_len_wr = 1'b0; cpu_len_wdata = '0; cpu_rd = 1'b0;
    host_wr = 1'b0; host_wbyte = '0; host_ack = 1'b0; host_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_in_full_packet();
    t_in_short_and_full();
    t_in_force();
    t_in_clip();
    t_out();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule